// File: doc/BRIEF.md
# Write Leveling Control Engine

This block runs the write leveling search on the controller side of a DRAM interface. Its job is to align the launch delay of each byte lane's DQS strobe with the memory clock as the DRAM sees it. After a start request it asks a mode-register sequencer to put the DRAM into leveling mode. It then works through the lanes one at a time. For each lane it fires a DQS burst, waits a programmable number of cycles, and reads the single bit that the DRAM sends back for that lane. That bit is the clock level the DRAM captured with the strobe.

The search is closed-loop. A returned 0 moves the lane's delay one tap up, and a returned 1 moves it one tap down. The lane is finished as soon as two adjacent taps give 0 and then 1. At that point the lane keeps the tap that returned 1. If the delay line runs out at either end before this happens, an error flag is raised and the engine moves on to the next lane. When the last lane is finished, the engine asks the sequencer to leave leveling mode, and it reports done only after that request is acknowledged.

Top module: `wl_engine`

## Requirements
- R1: After reset, done, err, mrw_req and dqs_fire are 0, and every lane's delay field in dqs_dly holds INIT_TAP (the mid tap, 2^(TAP_W-1)).
- R2: A start pulse in the idle state raises mrw_req with mrw_lvl=1. This is the value written to the leveling-enable bit, bit 7 of mode register 1. The request holds until mrw_ack, and no dqs_fire occurs before that acknowledge.
- R3: dqs_fire is a single-cycle pulse. Within one leveling pass, consecutive pulses are exactly W+2 cycles apart, where W is wait_cycles (0 allowed; 16 is the usual setting). The feedback is sampled W+1 cycles after each pulse.
- R4: A sampled feedback of 0 raises the lane's tap by one, and a sampled 1 lowers it by one, before the next burst.
- R5: When a lane's tap rises from a tap that returned 0 to a tap that returns 1, the lane ends and keeps the tap that returned 1.
- R6: When a lane's tap falls from a tap that returned 1 to a tap that returns 0, the lane ends with its tap one above the tap that returned 0.
- R7: Feedback 0 at the top tap (2^TAP_W-1), or feedback 1 at tap 0, sets err, leaves the lane at that boundary tap, and lets the next lane proceed.
- R8: Lanes are leveled in order from lane 0 upward. Each lane starts from INIT_TAP, and a lane's tap does not move while another lane is being searched.
- R9: After the last lane, mrw_req rises with mrw_lvl=0 (the leveling-enable bit cleared) and holds until mrw_ack. done then rises, and done and err hold until the next start, which clears both.
- R10: A lane's tap changes by at most one step per cycle, except for the reload to INIT_TAP at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a leveling pass (taken in idle) |
| wait_cycles | input | WAIT_W | Cycles to wait after a DQS burst before sampling |
| mrw_req | output | 1 | Mode-register write request to the sequencer |
| mrw_lvl | output | 1 | Value of the leveling-enable bit in the requested write |
| mrw_ack | input | 1 | Sequencer has completed the write |
| dqs_fire | output | 1 | Trigger for one DQS pulse burst |
| dq_fb | input | LANES | Captured clock level returned per lane |
| dqs_dly | output | LANES*TAP_W | Packed DQS delay taps, lane 0 in the low bits |
| done | output | 1 | Pass finished and leveling mode exited |
| err | output | 1 | Some lane hit a delay boundary without a transition |

## Verification
The hardest case to reach is the downward lock with step-back, together with the two boundary failures. Each one needs the feedback to flip at one exact tap relative to the start tap. The bench models the DRAM as a per-lane edge position that returns 1 at every tap at or above the edge. It then sweeps that edge across every tap from 0 to one past the top. This sweep walks through upward locks, downward locks, and both error exits, while the two lanes take unrelated edges and the wait count cycles through 0, 1, 5 and 16.

// File: rtl/wl_pkg.sv
`timescale 1ns/1ps
package wl_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LVL_ON, S_FIRE, S_WAIT, S_SAMPLE, S_LVL_OFF
  } wl_state_e;

  typedef enum logic [2:0] {
    ACT_UP, ACT_DOWN, ACT_HOLD, ACT_BACK, ACT_FAIL
  } wl_act_e;

  // Decision for one sample: seen = an earlier sample exists in this lane,
  // last = that earlier sample, now = current sample.
  function automatic wl_act_e wl_decide(input logic seen, input logic last,
                                        input logic now, input logic at_min,
                                        input logic at_max);
    if (seen && !last && now)      return ACT_HOLD;
    else if (seen && last && !now) return ACT_BACK;
    else if (!now)                 return at_max ? ACT_FAIL : ACT_UP;
    else                           return at_min ? ACT_FAIL : ACT_DOWN;
  endfunction

  // Tap after an action; BACK and UP both move one step up.
  function automatic logic [15:0] wl_step(input logic [15:0] tap, input wl_act_e act);
    case (act)
      ACT_UP, ACT_BACK: return tap + 16'd1;
      ACT_DOWN:         return tap - 16'd1;
      default:          return tap;
    endcase
  endfunction

endpackage

// File: rtl/wl_wait_timer.sv
`timescale 1ns/1ps
module wl_wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] ld_val,
  output logic              expired
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign expired = (cnt == ONE);

  AST_TIMER_IDLE_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> !expired); // R3
endmodule

// File: rtl/wl_tap_bank.sv
`timescale 1ns/1ps
module wl_tap_bank #(
  parameter int LANES  = 4,
  parameter int TAP_W  = 6,
  parameter int INIT_TAP = 32,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init,
  input  logic                     wr_en,
  input  logic [LANE_W-1:0]        wr_lane,
  input  logic [TAP_W-1:0]         wr_val,
  input  logic [LANE_W-1:0]        rd_lane,
  output logic [TAP_W-1:0]         rd_val,
  output logic [LANES*TAP_W-1:0]   taps
);
  localparam logic [TAP_W-1:0] INIT_V = TAP_W'(INIT_TAP);
  localparam logic [TAP_W:0]   ONE_X  = (TAP_W+1)'(1);

  logic [TAP_W-1:0] tap_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   tap_q[g] <= INIT_V;
      else if (init)                                tap_q[g] <= INIT_V;
      else if (wr_en && wr_lane == LANE_W'(g))      tap_q[g] <= wr_val;
    end
    assign taps[g*TAP_W +: TAP_W] = tap_q[g];

    AST_TAP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(init) |-> (tap_q[g] == $past(tap_q[g]) ||
                        {1'b0, tap_q[g]} == {1'b0, $past(tap_q[g])} + ONE_X ||
                        {1'b0, $past(tap_q[g])} == {1'b0, tap_q[g]} + ONE_X)); // R10
  end

  assign rd_val = tap_q[rd_lane];
endmodule

// File: rtl/wl_engine.sv
`timescale 1ns/1ps
module wl_engine
  import wl_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int TAP_W    = 6,
  parameter int WAIT_W   = 8,
  parameter int INIT_TAP = 1 << (TAP_W - 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [WAIT_W-1:0]      wait_cycles,
  output logic                   mrw_req,
  output logic                   mrw_lvl,
  input  logic                   mrw_ack,
  output logic                   dqs_fire,
  input  logic [LANES-1:0]       dq_fb,
  output logic [LANES*TAP_W-1:0] dqs_dly,
  output logic                   done,
  output logic                   err
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [TAP_W-1:0]  TAP_MAX   = '1;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  wl_state_e         state;
  logic [LANE_W-1:0] lane;
  logic              seen, last;
  logic              done_q, err_q;

  // named internal events
  logic              sample_evt, init_evt, wait_done, cur_fb, lane_end, tap_wr;
  logic [TAP_W-1:0]  cur_tap, nxt_tap;
  logic [15:0]       step_wide;
  wl_act_e           act;

  assign sample_evt = (state == S_SAMPLE);
  assign init_evt   = (state == S_IDLE) && start;
  assign cur_fb     = dq_fb[lane];
  assign act        = wl_decide(seen, last, cur_fb, cur_tap == '0, cur_tap == TAP_MAX);
  assign lane_end   = sample_evt && (act == ACT_HOLD || act == ACT_BACK || act == ACT_FAIL);
  assign tap_wr     = sample_evt && (act == ACT_UP || act == ACT_DOWN || act == ACT_BACK);
  assign step_wide  = wl_step(16'(cur_tap), act);
  assign nxt_tap    = step_wide[TAP_W-1:0];

  wl_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(state == S_FIRE),
    .ld_val(wait_cycles), .expired(wait_done)
  );

  wl_tap_bank #(.LANES(LANES), .TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_taps (
    .clk(clk), .rst_n(rst_n), .init(init_evt),
    .wr_en(tap_wr), .wr_lane(lane), .wr_val(nxt_tap),
    .rd_lane(lane), .rd_val(cur_tap), .taps(dqs_dly)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      lane   <= '0;
      seen   <= 1'b0;
      last   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_LVL_ON;
          lane   <= '0;
          seen   <= 1'b0;
          done_q <= 1'b0;
          err_q  <= 1'b0;
        end
        S_LVL_ON:  if (mrw_ack) state <= S_FIRE;
        S_FIRE:    state <= (wait_cycles == '0) ? S_SAMPLE : S_WAIT;
        S_WAIT:    if (wait_done) state <= S_SAMPLE;
        S_SAMPLE: begin
          if (act == ACT_FAIL) err_q <= 1'b1;
          if (lane_end) begin
            seen <= 1'b0;
            if (lane == LANE_LAST) state <= S_LVL_OFF;
            else begin
              lane  <= lane + LANE_W'(1);
              state <= S_FIRE;
            end
          end else begin
            seen  <= 1'b1;
            last  <= cur_fb;
            state <= S_FIRE;
          end
        end
        S_LVL_OFF: if (mrw_ack) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mrw_req  = (state == S_LVL_ON) || (state == S_LVL_OFF);
  assign mrw_lvl  = (state == S_LVL_ON);
  assign dqs_fire = (state == S_FIRE);
  assign done     = done_q;
  assign err      = err_q;

  AST_MRW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mrw_req && !mrw_ack |=> mrw_req && $stable(mrw_lvl)); // R2
  AST_NO_FIRE_DURING_MRW: assert property (@(posedge clk) disable iff (!rst_n)
    !(dqs_fire && mrw_req)); // R2
  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_fire |=> !dqs_fire); // R3
  AST_DONE_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mrw_req && !mrw_lvl && mrw_ack)); // R9
  AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(sample_evt && (cur_tap == '0 || cur_tap == TAP_MAX))); // R7
endmodule

// File: tb/wl_engine_bench.sv
`timescale 1ns/1ps
module wl_engine_bench;
  localparam int LANES  = 2;
  localparam int TAP_W  = 4;
  localparam int WAIT_W = 5;
  localparam int INIT   = 8;
  localparam int TMAX   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [WAIT_W-1:0] wait_cycles = '0;
  logic mrw_req, mrw_lvl, dqs_fire, done, err;
  logic mrw_ack = 1'b0;
  logic [LANES-1:0] dq_fb;
  logic [LANES*TAP_W-1:0] dqs_dly;

  int epos [LANES];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // DRAM model: returns 1 once the strobe delay reaches the lane's clock edge
  always_comb
    for (int l = 0; l < LANES; l++)
      dq_fb[l] = int'(dqs_dly[l*TAP_W +: TAP_W]) >= epos[l];

  wl_engine #(.LANES(LANES), .TAP_W(TAP_W), .WAIT_W(WAIT_W), .INIT_TAP(INIT)) u_wl_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_cycles(wait_cycles),
    .mrw_req(mrw_req), .mrw_lvl(mrw_lvl), .mrw_ack(mrw_ack), .dqs_fire(dqs_fire),
    .dq_fb(dq_fb), .dqs_dly(dqs_dly), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tap_of(input int l);
    return int'(dqs_dly[l*TAP_W +: TAP_W]);
  endfunction

  function automatic int exp_tap(input int e);
    if (e <= 0) return 0;
    if (e > TMAX) return TMAX;
    return e;
  endfunction

  function automatic int exp_fires(input int e);
    if (e > INIT) return ((e > TMAX) ? TMAX : e) - INIT + 1;
    return INIT - ((e > 0) ? e - 1 : 0) + 1;
  endfunction

  function automatic string tag_of(input int e);
    if (e <= 0 || e > TMAX) return "R7";
    if (e <= INIT) return "R6";
    return "R5";
  endfunction

  task automatic run_case(input int e0, input int e1, input int w);
    int cyc = 0, fires = 0, last_fire = -1, gap_bad = 0, order_bad = 0;
    int nmrw = 0, ack_wait = 0, early_fire = 0, step_bad = 0;
    int ev [2];
    int prev [LANES];
    bit first = 1'b1, timed_out = 1'b0, exp_err;
    epos[0] = e0;
    epos[1] = e1;
    ev[0] = -1;
    ev[1] = -1;
    wait_cycles = WAIT_W'(w);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == 1'b0, "R9 start clears done", int'(done), 0);
    while (!done) begin
      if (mrw_ack) begin
        mrw_ack = 1'b0;
        ack_wait = 0;
      end else if (mrw_req) begin
        ack_wait++;
        if (ack_wait == 2) begin
          mrw_ack = 1'b1;
          if (nmrw < 2) ev[nmrw] = int'(mrw_lvl);
          nmrw++;
        end
      end
      if (dqs_fire) begin
        fires++;
        if (last_fire >= 0 && cyc - last_fire != w + 2) gap_bad++;
        last_fire = cyc;
        if (nmrw != 1) early_fire++;
      end
      for (int l = 0; l < LANES; l++) begin
        if (!first && (tap_of(l) - prev[l] > 1 || prev[l] - tap_of(l) > 1)) step_bad++;
        prev[l] = tap_of(l);
      end
      first = 1'b0;
      if (tap_of(1) != INIT && tap_of(0) != exp_tap(e0)) order_bad++;
      cyc++;
      if (cyc > 4000) begin
        timed_out = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(!timed_out, "R9 done reached", int'(timed_out), 0);
    if (mrw_ack) @(negedge clk) mrw_ack = 1'b0;
    chk(ev[0] == 1, "R2 first mode write sets leveling bit", ev[0], 1);
    chk(ev[1] == 0, "R9 final mode write clears leveling bit", ev[1], 0);
    chk(nmrw == 2, "R9 mode write count", nmrw, 2);
    chk(early_fire == 0, "R2 strobes only inside leveling mode", early_fire, 0);
    chk(gap_bad == 0, "R3 strobe spacing", gap_bad, 0);
    chk(fires == exp_fires(e0) + exp_fires(e1), "R4 strobe count",
        fires, exp_fires(e0) + exp_fires(e1));
    chk(tap_of(0) == exp_tap(e0), {tag_of(e0), " lane0 final tap"}, tap_of(0), exp_tap(e0));
    chk(tap_of(1) == exp_tap(e1), {tag_of(e1), " R8 lane1 final tap"}, tap_of(1), exp_tap(e1));
    chk(order_bad == 0, "R8 lane order", order_bad, 0);
    chk(step_bad == 0, "R10 single-step moves", step_bad, 0);
    exp_err = (e0 <= 0 || e0 > TMAX || e1 <= 0 || e1 > TMAX);
    chk(err == exp_err, "R7 error flag", int'(err), int'(exp_err));
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && err == exp_err && mrw_req == 1'b0, "R9 done and err held",
        int'({done, err}), int'({1'b1, exp_err}));
  endtask

  initial begin
    #(2_000_000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    epos[0] = 0;
    epos[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R1 reset flags", int'({done, err}), 0);
    chk(mrw_req == 1'b0 && dqs_fire == 1'b0, "R1 reset outputs", int'({mrw_req, dqs_fire}), 0);
    chk(tap_of(0) == INIT && tap_of(1) == INIT, "R1 reset taps", tap_of(0), INIT);
    for (int i = 0; i <= TMAX + 1; i++) begin
      int w;
      case (i % 4)
        0: w = 0;
        1: w = 1;
        2: w = 5;
        default: w = 16;
      endcase
      run_case(i, (i * 5 + 3) % (TMAX + 2), w);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule